// File: doc/BRIEF.md
# Link Compliance Pattern Generator

This block supplies the fixed electrical compliance pattern that a serial link transmitter sends while link training holds it in the polling-compliance substate. The pattern is a four-symbol loop: a K28.5 comma, D21.5, a second K28.5, then D10.2. An 8b/10b encoder takes the bytes from this block, together with a per-byte control flag and a per-byte request to force negative running disparity. The training logic raises `enable` for as long as the substate lasts. The block feeds either an 8-bit parallel path (one symbol per clock) or a 16-bit path (two symbols per clock, earlier symbol in the low byte).

Each time `enable` rises, the loop restarts at the first K28.5. The disparity-force strobe marks only that first comma, because the encoder must start the pattern from negative disparity. The path width is captured when generation starts and then stays fixed until generation stops. All outputs come from registers, and each output word appears one clock after the edge that sampled `enable` high.

Top module: `compliance_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `tx_data`, `tx_is_k` and `tx_force_neg` are all zero.
- R2: After a clock edge that samples `enable` low, `tx_data` is 0x0000, `tx_is_k` is 2'b00 and `tx_force_neg` is 2'b00.
- R3: The first edge that samples `enable` high after it was low (or after reset) emits the first K28.5 (byte 0xBC with its K flag set) in the low byte. It becomes visible one clock later.
- R4: In 8-bit mode (`wide_mode` = 0) the low byte cycles 0xBC(K), 0xB5, 0xBC(K), 0x4A, one symbol per clock, with `tx_is_k[0]` set only on 0xBC. The high byte and `tx_is_k[1]` stay zero.
- R5: In 16-bit mode (`wide_mode` = 1) the words alternate 0xB5BC and 0x4ABC, starting with 0xB5BC. `tx_is_k` is 2'b01 on every word.
- R6: `tx_force_neg[0]` is high only on the first output word after `enable` rises, which in both modes has 0xBC in the low byte. `tx_force_neg[1]` is never high.
- R7: `wide_mode` is sampled at the edge where generation starts. Changing it while `enable` stays high has no effect on the output.
- R8: Dropping `enable` for at least one edge and raising it again restarts the loop at the first K28.5, with the force strobe set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| enable | input | 1 | High while the link is in the polling-compliance substate |
| wide_mode | input | 1 | Path width select: 0 for 8-bit, 1 for 16-bit |
| tx_data | output | 16 | Symbol bytes; lane 0 in bits 7:0, lane 1 in bits 15:8 |
| tx_is_k | output | 2 | Control-character flag for each lane |
| tx_force_neg | output | 2 | Request for each lane to force negative running disparity |

## Verification
The assertions assume that `rst_n` is released in step with `clk` and that `enable` and `wide_mode` are stable around each rising edge. The bench therefore changes every input on the falling edge. The K-flag alternation property in 8-bit mode assumes `enable` stays high across the two edges it spans, so the stimulus keeps most enable windows several cycles long. It also adds one single-cycle pulse, to cover the case where the force strobe and the only symbol coincide. Width changes are applied both while the block is idle and in the middle of a run, so that the capture of the width at start is exercised.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  localparam int SYM_W      = 8;
  localparam int PAT_LEN    = 4;
  localparam int PAT_IDX_W  = $clog2(PAT_LEN);

  localparam logic [SYM_W-1:0] COMMA_BYTE = 8'hBC;  // K28.5
  localparam logic [SYM_W-1:0] D21_5_BYTE = 8'hB5;
  localparam logic [SYM_W-1:0] D10_2_BYTE = 8'h4A;

  typedef struct packed {
    logic             is_k;
    logic [SYM_W-1:0] code;
  } sym_t;

  // Symbol at position idx of the loop; the order is behaviour
  function automatic sym_t pattern_sym(input logic [PAT_IDX_W-1:0] idx);
    sym_t s;
    case (idx)
      2'd0:    s = '{is_k: 1'b1, code: COMMA_BYTE};
      2'd1:    s = '{is_k: 1'b0, code: D21_5_BYTE};
      2'd2:    s = '{is_k: 1'b1, code: COMMA_BYTE};
      default: s = '{is_k: 1'b0, code: D10_2_BYTE};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cpg_seq.sv
module cpg_seq
  import cpg_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 wide_req,
  output logic [PAT_IDX_W-1:0] cur_idx,
  output logic                 cur_wide,
  output logic                 start
);

  localparam logic [PAT_IDX_W-1:0] WIDE_STEP   = PAT_IDX_W'(LANES);
  localparam logic [PAT_IDX_W-1:0] NARROW_STEP = PAT_IDX_W'(1);

  logic                 running_q, running_d;
  logic                 wide_q, wide_d;
  logic [PAT_IDX_W-1:0] idx_q, idx_d;

  assign start    = enable && !running_q;
  assign cur_idx  = start ? '0 : idx_q;
  assign cur_wide = start ? wide_req : wide_q;

  always_comb begin
    running_d = running_q;
    wide_d    = wide_q;
    idx_d     = idx_q;
    if (!enable) begin
      running_d = 1'b0;
      idx_d     = '0;
    end else begin
      running_d = 1'b1;
      wide_d    = cur_wide;
      idx_d     = cur_idx + (cur_wide ? WIDE_STEP : NARROW_STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      wide_q    <= 1'b0;
      idx_q     <= '0;
    end else begin
      running_q <= running_d;
      wide_q    <= wide_d;
      idx_q     <= idx_d;
    end
  end

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && enable) |=> (wide_q == $past(wide_q)));

  // R8
  restart_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (idx_q == '0 && !running_q));

endmodule

// File: rtl/cpg_lane_map.sv
module cpg_lane_map
  import cpg_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [PAT_IDX_W-1:0]   idx,
  input  logic                   wide,
  output logic [LANES*SYM_W-1:0] data,
  output logic [LANES-1:0]       is_k
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PAT_IDX_W-1:0] sel;
    sym_t                 sym;
    logic                 live;

    assign sel  = idx + PAT_IDX_W'(l);
    assign sym  = pattern_sym(sel);
    assign live = (l == 0) || wide;

    assign data[l*SYM_W +: SYM_W] = live ? sym.code : '0;
    assign is_k[l]                = live && sym.is_k;
  end

endmodule

// File: rtl/compliance_pattern_gen.sv
module compliance_pattern_gen
  import cpg_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   wide_mode,
  output logic [LANES*SYM_W-1:0] tx_data,
  output logic [LANES-1:0]       tx_is_k,
  output logic [LANES-1:0]       tx_force_neg
);

  localparam int DATA_W = LANES * SYM_W;

  logic [PAT_IDX_W-1:0] cur_idx;
  logic                 cur_wide;
  logic                 start;
  logic [DATA_W-1:0]    map_data;
  logic [LANES-1:0]     map_k;

  logic [DATA_W-1:0]    data_d;
  logic [LANES-1:0]     k_d;
  logic [LANES-1:0]     force_d;

  cpg_seq #(.LANES(LANES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .wide_req (wide_mode),
    .cur_idx  (cur_idx),
    .cur_wide (cur_wide),
    .start    (start)
  );

  cpg_lane_map #(.LANES(LANES)) u_map (
    .idx  (cur_idx),
    .wide (cur_wide),
    .data (map_data),
    .is_k (map_k)
  );

  always_comb begin
    data_d  = '0;
    k_d     = '0;
    force_d = '0;
    if (enable) begin
      data_d     = map_data;
      k_d        = map_k;
      force_d[0] = start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data      <= '0;
      tx_is_k      <= '0;
      tx_force_neg <= '0;
    end else begin
      tx_data      <= data_d;
      tx_is_k      <= k_d;
      tx_force_neg <= force_d;
    end
  end

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_data == '0 && tx_is_k == '0 && tx_force_neg == '0));

  // R6
  force_on_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_force_neg[0] |-> (tx_data[SYM_W-1:0] == COMMA_BYTE && tx_is_k[0]));

  // R6
  force_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_force_neg[0] && enable) |=> !tx_force_neg[0]);

  // R3
  start_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tx_data[SYM_W-1:0] == COMMA_BYTE && tx_force_neg[0]));

  // R4
  narrow_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cur_wide && tx_is_k[0] && !start) |=> !tx_is_k[0]);

  // R4
  narrow_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cur_wide) |=> (tx_data[DATA_W-1:SYM_W] == '0 && tx_is_k[LANES-1:1] == '0));

  // R5
  wide_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_wide) |=> (tx_is_k[0] && tx_data[SYM_W-1:0] == COMMA_BYTE));

endmodule

// File: tb/compliance_pattern_gen_test.sv
`timescale 1ns/1ps
module compliance_pattern_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        wide_mode;
  logic [15:0] tx_data;
  logic [1:0]  tx_is_k;
  logic [1:0]  tx_force_neg;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_run;
  bit          m_wide;
  int          m_idx;
  logic [15:0] e_data;
  logic [1:0]  e_k;
  logic [1:0]  e_force;
  string       e_tag;
  bit          model_on = 1'b0;

  always #2.5 clk = ~clk;

  compliance_pattern_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .wide_mode    (wide_mode),
    .tx_data      (tx_data),
    .tx_is_k      (tx_is_k),
    .tx_force_neg (tx_force_neg)
  );

  function automatic logic [7:0] sym_byte(int i);
    int p = i % 4;
    if (p == 0 || p == 2) return 8'hBC;
    if (p == 1) return 8'hB5;
    return 8'h4A;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_wide = 0; m_idx = 0;
      e_data = '0; e_k = '0; e_force = '0; e_tag = "R1";
    end else if (!enable) begin
      m_run = 0; m_idx = 0;
      e_data = '0; e_k = '0; e_force = '0; e_tag = "R2";
    end else begin
      e_force = 2'b00;
      if (!m_run) begin
        m_run = 1; m_wide = wide_mode; m_idx = 0; e_force = 2'b01;
      end
      e_data[7:0] = sym_byte(m_idx);
      e_k[0]      = (m_idx % 2) == 0;
      if (m_wide) begin
        e_data[15:8] = sym_byte(m_idx + 1);
        e_k[1]       = 1'b0;
        e_tag        = "R5";
        m_idx        = (m_idx + 2) % 4;
      end else begin
        e_data[15:8] = 8'h00;
        e_k[1]       = 1'b0;
        e_tag        = "R4";
        m_idx        = (m_idx + 1) % 4;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(e_tag, tx_data, e_data);
      chk(e_tag, {14'd0, tx_is_k}, {14'd0, e_k});
      chk("R6", {14'd0, tx_force_neg}, {14'd0, e_force});
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; wide_mode = 1'b0;
    cycles(3);
    // R1 reset state
    chk("R1", tx_data, 16'h0000);
    chk("R1", {14'd0, tx_is_k | tx_force_neg}, 16'h0000);
    // reset asserted while enable high keeps outputs clear
    enable = 1'b1;
    cycles(2);
    chk("R1", tx_data, 16'h0000);
    enable = 1'b0;
    cycles(1);
    rst_n = 1'b1;
    model_on = 1'b1;
    cycles(3);

    // 8-bit run; R3 first comma one clock after enable
    wide_mode = 1'b0; enable = 1'b1;
    cycles(1);
    chk("R3", tx_data, 16'h00BC);
    chk("R3", {14'd0, tx_force_neg}, 16'h0001);
    cycles(1);
    chk("R4", tx_data, 16'h00B5);
    cycles(1);
    chk("R4", tx_data, 16'h00BC);
    chk("R6", {14'd0, tx_force_neg}, 16'h0000);
    cycles(1);
    chk("R4", tx_data, 16'h004A);
    // R7 width change mid-run ignored
    wide_mode = 1'b1;
    cycles(1);
    chk("R7", tx_data, 16'h00BC);
    cycles(6);
    chk("R7", tx_data[15:8], 8'h00);

    // R8 restart after gap, now 16-bit
    enable = 1'b0;
    cycles(2);
    enable = 1'b1;
    cycles(1);
    chk("R8", tx_data, 16'hB5BC);
    chk("R8", {14'd0, tx_force_neg}, 16'h0001);
    cycles(1);
    chk("R5", tx_data, 16'h4ABC);
    chk("R5", {14'd0, tx_is_k}, 16'h0001);
    wide_mode = 1'b0;
    cycles(1);
    chk("R7", tx_data, 16'hB5BC);
    cycles(5);

    // single-cycle pulse in 8-bit mode
    enable = 1'b0;
    cycles(1);
    enable = 1'b1;
    cycles(1);
    chk("R8", tx_data, 16'h00BC);
    enable = 1'b0;
    cycles(1);
    chk("R2", tx_data, 16'h0000);
    chk("R2", {14'd0, tx_force_neg}, 16'h0000);
    cycles(3);

    // mode changed while idle is taken at the next start
    wide_mode = 1'b1;
    cycles(2);
    enable = 1'b1;
    cycles(9);
    enable = 1'b0;
    cycles(3);

    model_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule